// File: doc/BRIEF.md
# Processor Status Flag Word

This block keeps the status flag word of a processor core. Each cycle it can take a full-word load from software, per-flag results from the ALU and the automatic clears that come with accepting an interrupt. All three sources can be active in the same cycle, and a fixed priority decides which one sets each bit. The core uses the register-bank, stack-pointer and interrupt-enable bits directly. A debug bit makes the block raise a single-step interrupt request after each completed instruction.

The core decodes the word by fixed bit position. Bit 0 is carry, bit 1 is debug, bit 2 is zero, bit 3 is sign, bit 4 is bank select, bit 5 is overflow, bit 6 is interrupt enable and bit 7 is stack select. All bits above bit 7 are reserved.

Top module: `status_word_reg`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, flags_out is all zero and step_req is 0.
- R2: bank_sel follows bit 4 of the word, mask_irq_en follows bit 6 and sp_sel follows bit 7. A value of 0 selects bank 0, interrupts disabled and the interrupt stack pointer.
- R3: Bits 8 to 11 always read 0, and a software write cannot set them.
- R4: When sw_wr is 1, bits 0 to 7 take sw_data[7:0] on the next clock edge. A bit claimed by a higher-priority source in the same cycle is the exception.
- R5: The ALU enables and values map as follows: alu_upd[0]/alu_val[0] load carry (bit 0), index 1 loads zero (bit 2), index 2 loads sign (bit 3) and index 3 loads overflow (bit 5). A flag whose enable is 0 keeps its value.
- R6: When the ALU and a software write target the same flag in one cycle, the ALU value is stored.
- R7: ack_stb clears debug (bit 1) and interrupt enable (bit 6) on the next edge, even if a software write sets them in the same cycle.
- R8: ack_stb with ack_is_sw=0 clears stack select (bit 7). A software acknowledge (ack_is_sw=1) clears it only when ack_vec is 0 to 31. A software acknowledge with ack_vec of 32 or more leaves bit 7 unchanged.
- R9: step_req is 1 in the cycle after any cycle in which insn_done is 1 and the stored debug bit is 1. Otherwise step_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_upd | input | 4 | Per-flag ALU update enables (carry, zero, sign, overflow) |
| alu_val | input | 4 | ALU flag values, same order as alu_upd |
| sw_wr | input | 1 | Software write strobe |
| sw_data | input | 12 | Software write data |
| ack_stb | input | 1 | Interrupt accepted strobe |
| ack_is_sw | input | 1 | 1 for a software interrupt, 0 for a hardware interrupt |
| ack_vec | input | 6 | Software interrupt vector number |
| insn_done | input | 1 | Instruction completed strobe |
| flags_out | output | 12 | Flag word |
| bank_sel | output | 1 | Register bank select |
| sp_sel | output | 1 | Stack pointer select (1 selects the user stack pointer) |
| mask_irq_en | output | 1 | Maskable interrupt enable |
| step_req | output | 1 | Single-step interrupt request |

## Verification
The embedded properties check the following on every cycle:
- the reserved bits stay at zero;
- an acknowledge clears the debug and enable bits;
- a hardware acknowledge clears stack select, and a software acknowledge at vector 32 or above leaves it unchanged;
- each enabled ALU flag lands in the word;
- step_req appears only after a completed instruction with debug set.

Only the bench scenarios can show some things. These are the exact full-word results of mixed sources, the boundary between vectors 31 and 32, the decoded select outputs, and step_req staying low when debug is clear.

// File: rtl/flagreg_pkg.sv
package flagreg_pkg;
   localparam int FB_CARRY = 0;
   localparam int FB_DEBUG = 1;
   localparam int FB_ZERO  = 2;
   localparam int FB_SIGN  = 3;
   localparam int FB_BANK  = 4;
   localparam int FB_OVF   = 5;
   localparam int FB_IEN   = 6;
   localparam int FB_STACK = 7;
   localparam int FB_LIVE  = 8;
   localparam int ALU_N    = 4;

   typedef struct packed {
      logic ovf;
      logic sign;
      logic zero;
      logic carry;
   } alu_flags_t;

   function automatic int alu_pos(input int idx);
      case (idx)
         0:       return FB_CARRY;
         1:       return FB_ZERO;
         2:       return FB_SIGN;
         default: return FB_OVF;
      endcase
   endfunction
endpackage

// File: rtl/flag_alu_merge.sv
module flag_alu_merge
   import flagreg_pkg::*;
#(
   parameter int WORD_W = 12
) (
   input  logic [WORD_W-1:0] base,
   input  logic [ALU_N-1:0]  upd,
   input  logic [ALU_N-1:0]  val,
   output logic [WORD_W-1:0] merged
);
   logic [WORD_W-1:0] sel_mask;
   logic [WORD_W-1:0] sel_val;

   always_comb begin
      sel_mask = '0;
      sel_val  = '0;
      for (int k = 0; k < ALU_N; k++) begin
         sel_mask[alu_pos(k)] = upd[k];
         sel_val[alu_pos(k)]  = val[k];
      end
   end

   assign merged = (base & ~sel_mask) | (sel_val & sel_mask);
endmodule

// File: rtl/flag_irq_clear.sv
module flag_irq_clear
   import flagreg_pkg::*;
#(
   parameter int WORD_W      = 12,
   parameter int VEC_W       = 6,
   parameter int SW_SP_LIMIT = 32
) (
   input  logic              ack_stb,
   input  logic              ack_is_sw,
   input  logic [VEC_W-1:0]  ack_vec,
   output logic [WORD_W-1:0] clr_mask
);
   localparam logic [VEC_W:0] LIM_V = SW_SP_LIMIT[VEC_W:0];

   if (VEC_W < 1 || VEC_W > 16) begin : g_bad_vec
      $error("flag_irq_clear: VEC_W out of range");
   end
   if (SW_SP_LIMIT < 0 || SW_SP_LIMIT > (1 << VEC_W)) begin : g_bad_lim
      $error("flag_irq_clear: SW_SP_LIMIT out of range");
   end

   logic low_vec;
   logic sp_clr;

   assign low_vec = ({1'b0, ack_vec} < LIM_V);
   assign sp_clr  = ack_stb & (~ack_is_sw | low_vec);

   always_comb begin
      clr_mask           = '0;
      clr_mask[FB_DEBUG] = ack_stb;
      clr_mask[FB_IEN]   = ack_stb;
      clr_mask[FB_STACK] = sp_clr;
   end
endmodule

// File: rtl/flag_step_gen.sv
module flag_step_gen #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic insn_done,
   input  logic dbg,
   output logic step_req
);
   if (REGISTERED) begin : g_reg
      logic req_q;
      always_ff @(posedge clk) begin
         if (!rst_n) req_q <= 1'b0;
         else        req_q <= insn_done & dbg;
      end
      assign step_req = req_q;

      // R9
      step_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         step_req |-> $past(insn_done && dbg));
   end else begin : g_comb
      assign step_req = insn_done & dbg;
   end
endmodule

// File: rtl/status_word_reg.sv
module status_word_reg
   import flagreg_pkg::*;
#(
   parameter int WORD_W      = 12,
   parameter int VEC_W       = 6,
   parameter int SW_SP_LIMIT = 32,
   parameter bit STEP_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        alu_upd,
   input  logic [3:0]        alu_val,
   input  logic              sw_wr,
   input  logic [WORD_W-1:0] sw_data,
   input  logic              ack_stb,
   input  logic              ack_is_sw,
   input  logic [VEC_W-1:0]  ack_vec,
   input  logic              insn_done,
   output logic [WORD_W-1:0] flags_out,
   output logic              bank_sel,
   output logic              sp_sel,
   output logic              mask_irq_en,
   output logic              step_req
);
   if (WORD_W < FB_LIVE) begin : g_bad_w
      $error("status_word_reg: WORD_W must cover the eight live flags");
   end

   function automatic logic [WORD_W-1:0] live_mask();
      logic [WORD_W-1:0] m;
      for (int i = 0; i < WORD_W; i++) m[i] = (i < FB_LIVE);
      return m;
   endfunction

   localparam logic [WORD_W-1:0] LIVE_MASK = live_mask();

   logic [WORD_W-1:0] flag_q;
   logic [WORD_W-1:0] sw_stage;
   logic [WORD_W-1:0] alu_stage;
   logic [WORD_W-1:0] clr_mask;
   logic [WORD_W-1:0] flag_d;
   alu_flags_t        alu_upd_s;
   alu_flags_t        alu_val_s;

   assign alu_upd_s = alu_upd;
   assign alu_val_s = alu_val;

   // lowest priority: software write of the live bits
   assign sw_stage = sw_wr ? (sw_data & LIVE_MASK) : flag_q;

   flag_alu_merge #(.WORD_W(WORD_W)) u_alu (
      .base   (sw_stage),
      .upd    (alu_upd_s),
      .val    (alu_val_s),
      .merged (alu_stage)
   );

   flag_irq_clear #(
      .WORD_W      (WORD_W),
      .VEC_W       (VEC_W),
      .SW_SP_LIMIT (SW_SP_LIMIT)
   ) u_clr (
      .ack_stb   (ack_stb),
      .ack_is_sw (ack_is_sw),
      .ack_vec   (ack_vec),
      .clr_mask  (clr_mask)
   );

   // highest priority: acknowledge clears
   assign flag_d = alu_stage & ~clr_mask & LIVE_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag_d;
   end

   assign flags_out   = flag_q;
   assign bank_sel    = flag_q[FB_BANK];
   assign sp_sel      = flag_q[FB_STACK];
   assign mask_irq_en = flag_q[FB_IEN];

   flag_step_gen #(.REGISTERED(STEP_REG)) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .insn_done (insn_done),
      .dbg       (flag_q[FB_DEBUG]),
      .step_req  (step_req)
   );

   if (WORD_W > FB_LIVE) begin : g_rsv_chk
      // R3
      rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         flags_out[WORD_W-1:FB_LIVE] == '0);
   end

   // R7
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_stb |=> (!flags_out[FB_DEBUG] && !mask_irq_en));

   // R8
   hw_sp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_stb && !ack_is_sw) |=> !sp_sel);

   // R8
   sw_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_stb && ack_is_sw && (int'(ack_vec) >= SW_SP_LIMIT) && !sw_wr)
         |=> (sp_sel == $past(sp_sel)));

   for (genvar k = 0; k < ALU_N; k++) begin : g_alu_chk
      // R6
      alu_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
         alu_upd[k] |=> (flags_out[alu_pos(k)] == $past(alu_val[k])));
   end
endmodule

// File: tb/tb_status_word_reg.sv
module tb_status_word_reg;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  alu_upd, alu_val;
   logic        sw_wr;
   logic [11:0] sw_data;
   logic        ack_stb, ack_is_sw;
   logic [5:0]  ack_vec;
   logic        insn_done;
   logic [11:0] flags_out;
   logic        bank_sel, sp_sel, mask_irq_en, step_req;

   int checks = 0;
   int failures = 0;
   logic [11:0] model = '0;
   logic        exp_step = 1'b0;

   always #10 clk = ~clk;

   status_word_reg dut (
      .clk(clk), .rst_n(rst_n), .alu_upd(alu_upd), .alu_val(alu_val),
      .sw_wr(sw_wr), .sw_data(sw_data), .ack_stb(ack_stb),
      .ack_is_sw(ack_is_sw), .ack_vec(ack_vec), .insn_done(insn_done),
      .flags_out(flags_out), .bank_sel(bank_sel), .sp_sel(sp_sel),
      .mask_irq_en(mask_irq_en), .step_req(step_req)
   );

   function automatic logic [11:0] model_next(
      input logic [11:0] cur, input logic wr, input logic [11:0] d,
      input logic [3:0] upd, input logic [3:0] val,
      input logic ack, input logic is_sw, input logic [5:0] vec);
      logic [11:0] n;
      n = cur;
      if (wr) n = d & 12'h0FF;
      if (upd[0]) n[0] = val[0];
      if (upd[1]) n[2] = val[1];
      if (upd[2]) n[3] = val[2];
      if (upd[3]) n[5] = val[3];
      if (ack) begin
         n[1] = 1'b0;
         n[6] = 1'b0;
         if (!is_sw || vec < 6'd32) n[7] = 1'b0;
      end
      return n;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input string tag, input logic wr, input logic [11:0] d,
                      input logic [3:0] upd, input logic [3:0] val,
                      input logic ack, input logic is_sw, input logic [5:0] vec,
                      input logic done);
      @(negedge clk);
      sw_wr = wr; sw_data = d; alu_upd = upd; alu_val = val;
      ack_stb = ack; ack_is_sw = is_sw; ack_vec = vec; insn_done = done;
      exp_step = done & model[1];
      model = model_next(model, wr, d, upd, val, ack, is_sw, vec);
      @(posedge clk);
      #1;
      check({tag, " word"}, {20'd0, flags_out}, {20'd0, model});
      check("R2 bank_sel", {31'd0, bank_sel}, {31'd0, model[4]});
      check("R2 sp_sel", {31'd0, sp_sel}, {31'd0, model[7]});
      check("R2 mask_irq_en", {31'd0, mask_irq_en}, {31'd0, model[6]});
      check("R9 step_req", {31'd0, step_req}, {31'd0, exp_step});
   endtask

   initial begin
      #(20ns * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; sw_wr = 1'b1; sw_data = 12'hFFF; alu_upd = 4'hF; alu_val = 4'hF;
      ack_stb = 1'b0; ack_is_sw = 1'b0; ack_vec = '0; insn_done = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset word", {20'd0, flags_out}, 32'd0);
      check("R1 reset step", {31'd0, step_req}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1; sw_wr = 1'b0; alu_upd = '0; insn_done = 1'b0;
      model = '0;

      // R3 R4: full write, reserved bits stay zero
      cyc("R3_R4 write all", 1, 12'hFFF, 4'h0, 4'h0, 0, 0, 6'd0, 0);
      // R8: software vector 40 keeps stack select; R7 clears debug and enable
      cyc("R8 sw vec40", 0, 12'h000, 4'h0, 4'h0, 1, 1, 6'd40, 0);
      cyc("R4 rewrite", 1, 12'h0FF, 4'h0, 4'h0, 0, 0, 6'd0, 0);
      cyc("R8 sw vec32", 0, 12'h000, 4'h0, 4'h0, 1, 1, 6'd32, 0);
      cyc("R8 sw vec31", 0, 12'h000, 4'h0, 4'h0, 1, 1, 6'd31, 0);
      cyc("R4 rewrite2", 1, 12'h0FF, 4'h0, 4'h0, 0, 0, 6'd0, 0);
      cyc("R8 hw ack", 0, 12'h000, 4'h0, 4'h0, 1, 0, 6'd50, 0);
      // R7: acknowledge beats a simultaneous write
      cyc("R7 ack over write", 1, 12'h0FF, 4'h0, 4'h0, 1, 1, 6'd60, 0);
      // R6 R5: ALU beats software on the same bits
      cyc("R6 alu over write", 1, 12'h000, 4'hF, 4'hF, 0, 0, 6'd0, 0);
      cyc("R5 partial alu", 0, 12'h000, 4'h5, 4'h0, 0, 0, 6'd0, 0);
      // R9: single step
      cyc("R9 set debug", 1, 12'h002, 4'h0, 4'h0, 0, 0, 6'd0, 0);
      cyc("R9 done with debug", 0, 12'h000, 4'h0, 4'h0, 0, 0, 6'd0, 1);
      cyc("R9 idle", 0, 12'h000, 4'h0, 4'h0, 0, 0, 6'd0, 0);
      cyc("R9 clear debug", 1, 12'h000, 4'h0, 4'h0, 0, 0, 6'd0, 0);
      cyc("R9 done no debug", 0, 12'h000, 4'h0, 4'h0, 0, 0, 6'd0, 1);

      for (int i = 0; i < 3000; i++) begin
         cyc("R4_R5_R6_R7_R8 random",
             ($urandom % 10) < 3, 12'($urandom),
             4'($urandom), 4'($urandom),
             ($urandom % 8) == 0, 1'($urandom), 6'($urandom),
             ($urandom % 5) < 2);
      end

      // R1: reset again from an arbitrary state
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      check("R1 mid reset", {20'd0, flags_out}, 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule